// File: doc/BRIEF.md
# Interval Timer with Interrupt Flags

This block is a bus-attached peripheral timer. A 16-bit down-counter is loaded from a 16-bit reload latch. The counter decrements once for each pulse on a tick-enable input. That input comes from a timebase that is independent of the CPU bus, so the timer keeps counting while the processor is stalled or single-stepping. Every underflow can raise a timer flag. The flag is visible in an interrupt-flag register, and it drives a level interrupt output when the matching bit in the interrupt-enable register is set. A mode bit in the auxiliary control register selects between two behaviours:

- **Free-running:** the counter reloads from the latch and flags on every underflow.
- **One-shot:** the counter flags once after each start, then wraps and keeps counting without flagging again.

The CPU side is a plain synchronous register bus. An access is one cycle with chip select plus a write or read strobe. Write data is taken at that clock edge. Read data is registered and appears on `rdata` on the cycle after the read strobe. The bus has no back-pressure: every access completes in one cycle and none can be stalled. Only the low four address bits are decoded. The sixteen registers therefore repeat through a 256-byte chip-select window.

Registers with no timer function behave as plain bytes that read back the last value written. These are the port and direction registers, the second timer, the shift register and the peripheral control register. A typical driver does the following, in order:

1. Writes the low reload byte.
2. Writes the counter high byte, which starts the timer.
3. Selects the mode.
4. Either polls flag bit 6 or enables it as an interrupt.
5. Acknowledges by reading the counter low byte.

Top module: `tmr_top`

## Requirements
- R1: After reset the counter, latch, flags, enables and plain bytes are zero, `irq` is low, and the enable register (offset 14) reads 0x80.
- R2: A write to offset 5 does three things: it sets the latch high byte to the write data, copies the full latch into the counter, and arms the timer. This load takes priority over a tick in the same cycle.
- R3: The counter drops by one on each clock with `tick` high. A tick while the counter is 0 is an underflow, so the underflow period is latch+1 ticks.
- R4: With auxiliary control (offset 11) bit 6 = 1 (free-running), each underflow reloads the counter from the latch and sets flag bit 6.
- R5: With offset 11 bit 6 = 0 (one-shot), an underflow wraps the counter to 0xFFFF. It sets flag bit 6 only on the first underflow after a start and never again until the next write to offset 5.
- R6: Reads at offsets 4, 5, 6 and 7 return, in that order, counter low, counter high, latch low and latch high. A write to offset 4 or 6 changes only the latch low byte.
- R7: A read of offset 4 clears flag bit 6. If an underflow sets the flag in the same cycle, the set wins.
- R8: The flag register is at offset 13. Bit 6 is the timer flag and bit 7 reads as the OR of flags that are both set and enabled. `irq` equals bit 7. Writing 1s to bits 6..0 clears those flags.
- R9: The enable register is at offset 14. A write with bit 7 = 1 sets the enables marked by 1s in bits 6..0, and a write with bit 7 = 0 clears them. Bit 7 always reads 1.
- R10: A write to offset 7 updates only the latch high byte and clears flag bit 6. The counter does not change.
- R11: Offsets 0–3, 8–10, 11, 12 and 15 read back the last byte written.
- R12: Address bits 7..4 are ignored: offset N is reached at any address whose low nibble is N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase enable, one pulse per count (synchronous to `clk`) |
| cs | input | 1 | Chip select for the 256-byte window |
| we | input | 1 | Write strobe, qualified by `cs` |
| re | input | 1 | Read strobe, qualified by `cs` |
| addr | input | 8 | Byte address within the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after a read strobe |
| irq | output | 1 | Level interrupt request, active high |

## Verification
The assertions rely on the following properties of the inputs:

- `tick` is a single-cycle enable already synchronous to `clk`.
- Each access asserts at most one of `we` and `re`.
- `addr` and `wdata` are stable for the strobed cycle.

On those terms, decrement, reload, wrap and load behaviour can be stated cycle by cycle. The stimulus holds every strobe for exactly one clock and never raises `we` and `re` together. It raises `tick` with an access only in the two directed races, where load or flag-set priority is the point under test.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int TMR_FLAG_BIT = 6;
  localparam int FREERUN_BIT  = 6;
  localparam int SETCLR_BIT   = 7;

  typedef enum logic [3:0] {
    OFS_CNT_LO = 4'd4,
    OFS_CNT_HI = 4'd5,
    OFS_LAT_LO = 4'd6,
    OFS_LAT_HI = 4'd7,
    OFS_AUX    = 4'd11,
    OFS_FLAGS  = 4'd13,
    OFS_ENABLE = 4'd14
  } reg_ofs_e;

  typedef struct packed {
    logic wr_cnt_lo;
    logic wr_cnt_hi;
    logic wr_lat_lo;
    logic wr_lat_hi;
    logic wr_flags;
    logic wr_enable;
    logic rd_cnt_lo;
  } strobe_t;

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int SEL_W = 4,
  localparam int NREG = 1 << SEL_W
) (
  input  logic             cs,
  input  logic             we,
  input  logic             re,
  input  logic [SEL_W-1:0] sel,
  output strobe_t          strb,
  output logic [NREG-1:0]  store_we
);

  logic wr, rd;

  always_comb begin
    wr = cs & we;
    rd = cs & re;
    strb.wr_cnt_lo = wr && (sel == SEL_W'(OFS_CNT_LO));
    strb.wr_cnt_hi = wr && (sel == SEL_W'(OFS_CNT_HI));
    strb.wr_lat_lo = wr && (sel == SEL_W'(OFS_LAT_LO));
    strb.wr_lat_hi = wr && (sel == SEL_W'(OFS_LAT_HI));
    strb.wr_flags  = wr && (sel == SEL_W'(OFS_FLAGS));
    strb.wr_enable = wr && (sel == SEL_W'(OFS_ENABLE));
    strb.rd_cnt_lo = rd && (sel == SEL_W'(OFS_CNT_LO));
    for (int i = 0; i < NREG; i++) begin
      store_we[i] = wr && (sel == SEL_W'(i));
    end
  end

endmodule

// File: rtl/tmr_store.sv
module tmr_store #(
  parameter int              NREG       = 16,
  parameter int              DW         = 8,
  parameter logic [NREG-1:0] PLAIN_MASK = 16'h9F0F
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREG-1:0]          store_we,
  input  logic [DW-1:0]            wdata,
  output logic [NREG-1:0][DW-1:0]  bytes_q
);

  for (genvar g = 0; g < NREG; g++) begin : g_byte
    if (PLAIN_MASK[g]) begin : g_kept
      always_ff @(posedge clk) begin
        if (!rst_n)           bytes_q[g] <= '0;
        else if (store_we[g]) bytes_q[g] <= wdata;
      end
    end else begin : g_none
      assign bytes_q[g] = '0;
    end
  end

endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int DW = 8,
  localparam int CNT_W = 2 * DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             freerun,
  input  strobe_t          strb,
  input  logic [DW-1:0]    wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] lat_q,
  output logic             armed_q,
  output logic             underflow,
  output logic             flag_set
);

  logic at_zero;

  always_comb begin
    at_zero   = (cnt_q == '0);
    underflow = tick && !strb.wr_cnt_hi && at_zero;
    flag_set  = underflow && (freerun || armed_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      lat_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (strb.wr_cnt_lo || strb.wr_lat_lo) lat_q[DW-1:0] <= wdata;
      if (strb.wr_lat_hi || strb.wr_cnt_hi) lat_q[CNT_W-1:DW] <= wdata;
      if (strb.wr_cnt_hi) begin
        cnt_q   <= {wdata, lat_q[DW-1:0]};
        armed_q <= 1'b1;
      end else if (tick) begin
        if (at_zero && freerun) begin
          cnt_q <= lat_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
          if (at_zero) armed_q <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq
  import tmr_pkg::*;
#(
  parameter int DW = 8,
  localparam int NFLAG = DW - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_vec,
  input  logic             clr_tmr,
  input  logic             wr_flags,
  input  logic             wr_enable,
  input  logic [DW-1:0]    wdata,
  output logic [NFLAG-1:0] ifr_q,
  output logic [NFLAG-1:0] ier_q,
  output logic             irq
);

  logic [NFLAG-1:0] clr_vec;

  always_comb begin
    clr_vec = '0;
    if (wr_flags) clr_vec = wdata[NFLAG-1:0];
    if (clr_tmr)  clr_vec[TMR_FLAG_BIT] = 1'b1;
    irq = |(ifr_q & ier_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ifr_q <= '0;
      ier_q <= '0;
    end else begin
      ifr_q <= (ifr_q & ~clr_vec) | set_vec;
      if (wr_enable) begin
        if (wdata[SETCLR_BIT]) ier_q <= ier_q | wdata[NFLAG-1:0];
        else                   ier_q <= ier_q & ~wdata[NFLAG-1:0];
      end
    end
  end

endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SEL_W  = 4,
  parameter int DW     = 8,
  localparam int NREG  = 1 << SEL_W,
  localparam int CNT_W = 2 * DW,
  localparam int NFLAG = DW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cs,
  input  logic          we,
  input  logic          re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);

  logic [SEL_W-1:0]        sel;
  logic                    unused_addr_hi;
  strobe_t                 strb;
  logic [NREG-1:0]         store_we;
  logic [NREG-1:0][DW-1:0] bytes_q;
  logic [CNT_W-1:0]        cnt_q, lat_q;
  logic                    armed_q, uf, flag_set, freerun, load_ev, tflag;
  logic [NFLAG-1:0]        set_vec, ifr_q, ier_q;
  logic [DW-1:0]           rd_mux;

  assign sel            = addr[SEL_W-1:0];
  assign unused_addr_hi = ^addr[ADDR_W-1:SEL_W];
  assign freerun        = bytes_q[OFS_AUX][FREERUN_BIT];
  assign load_ev        = strb.wr_cnt_hi;
  assign tflag          = ifr_q[TMR_FLAG_BIT];

  tmr_decode #(.SEL_W(SEL_W)) u_dec (
    .cs(cs), .we(we), .re(re), .sel(sel), .strb(strb), .store_we(store_we)
  );

  tmr_store #(.NREG(NREG), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .store_we(store_we), .wdata(wdata), .bytes_q(bytes_q)
  );

  tmr_count #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .freerun(freerun), .strb(strb),
    .wdata(wdata), .cnt_q(cnt_q), .lat_q(lat_q), .armed_q(armed_q),
    .underflow(uf), .flag_set(flag_set)
  );

  always_comb begin
    set_vec = '0;
    set_vec[TMR_FLAG_BIT] = flag_set;
  end

  tmr_irq #(.DW(DW)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .clr_tmr(strb.rd_cnt_lo | strb.wr_lat_hi),
    .wr_flags(strb.wr_flags), .wr_enable(strb.wr_enable), .wdata(wdata),
    .ifr_q(ifr_q), .ier_q(ier_q), .irq(irq)
  );

  always_comb begin
    case (sel)
      SEL_W'(OFS_CNT_LO): rd_mux = cnt_q[DW-1:0];
      SEL_W'(OFS_CNT_HI): rd_mux = cnt_q[CNT_W-1:DW];
      SEL_W'(OFS_LAT_LO): rd_mux = lat_q[DW-1:0];
      SEL_W'(OFS_LAT_HI): rd_mux = lat_q[CNT_W-1:DW];
      SEL_W'(OFS_FLAGS):  rd_mux = {irq, ifr_q};
      SEL_W'(OFS_ENABLE): rd_mux = {1'b1, ier_q};
      default:            rd_mux = bytes_q[sel];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         rdata <= '0;
    else if (cs && re)  rdata <= rd_mux;
  end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int SEL_W = 4,
  parameter int DW    = 8,
  localparam int CNT_W = 2 * DW
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cs,
  input logic             re,
  input logic [SEL_W-1:0] sel,
  input logic [DW-1:0]    wdata,
  input logic [DW-1:0]    rdata,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] lat_q,
  input logic             freerun,
  input logic             armed_q,
  input logic             tflag,
  input logic             uf,
  input logic             load_ev
);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (armed_q && cnt_q == {$past(wdata), $past(lat_q[DW-1:0])}));

  assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_ev && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && freerun) |=> (cnt_q == $past(lat_q) && tflag));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && !freerun) |=> (cnt_q == '1 && !armed_q));

  assert_oneshot_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && !freerun && !armed_q) |=> !$rose(tflag));

  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && re && sel == SEL_W'(4) && !uf) |=> !tflag);

  assert_enable_msb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && re && sel == SEL_W'(14)) |=> rdata[DW-1]);

endmodule

bind tmr_top tmr_checker #(.SEL_W(SEL_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cs(cs), .re(re), .sel(sel),
  .wdata(wdata), .rdata(rdata), .cnt_q(cnt_q), .lat_q(lat_q),
  .freerun(freerun), .armed_q(armed_q), .tflag(tflag), .uf(uf),
  .load_ev(load_ev)
);

// File: tb/tmr_top_test.sv
module tmr_top_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_IRQ = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  req;
    logic [7:0]  addr;
    logic [17:0] arg;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 52;
  localparam vec_t VECS [NV] = '{
    '{OP_WR, 4'd5,  8'h0B, 18'h00,    8'h00}, // R5 one-shot mode
    '{OP_WR, 4'd9,  8'h0E, 18'hC0,    8'h00}, // R9 enable timer flag
    '{OP_RD, 4'd9,  8'h0E, 18'd0,     8'hC0}, // R9
    '{OP_WR, 4'd6,  8'h06, 18'h03,    8'h00}, // R6 latch low
    '{OP_WR, 4'd2,  8'h05, 18'h00,    8'h00}, // R2 start
    '{OP_RD, 4'd2,  8'h04, 18'd0,     8'h03}, // R2 counter loaded
    '{OP_TK, 4'd3,  8'h00, 18'd3,     8'h00}, // R3
    '{OP_RD, 4'd3,  8'h04, 18'd0,     8'h00}, // R3
    '{OP_RD, 4'd3,  8'h0D, 18'd0,     8'h00}, // R3 no flag yet
    '{OP_TK, 4'd3,  8'h00, 18'd1,     8'h00}, // R3 underflow
    '{OP_RD, 4'd8,  8'h0D, 18'd0,     8'hC0}, // R8
    '{OP_IRQ,4'd8,  8'h00, 18'd0,     8'h01}, // R8
    '{OP_RD, 4'd5,  8'h05, 18'd0,     8'hFF}, // R5 wrap
    '{OP_RD, 4'd7,  8'h04, 18'd0,     8'hFF}, // R7 read clears
    '{OP_RD, 4'd7,  8'h0D, 18'd0,     8'h00}, // R7
    '{OP_IRQ,4'd8,  8'h00, 18'd0,     8'h00}, // R8
    '{OP_TK, 4'd5,  8'h00, 18'd65535, 8'h00}, // R5
    '{OP_RD, 4'd5,  8'h04, 18'd0,     8'h00}, // R5
    '{OP_RD, 4'd5,  8'h05, 18'd0,     8'h00}, // R5
    '{OP_TK, 4'd5,  8'h00, 18'd1,     8'h00}, // R5 second underflow
    '{OP_RD, 4'd5,  8'h0D, 18'd0,     8'h00}, // R5 no refire
    '{OP_RD, 4'd5,  8'h05, 18'd0,     8'hFF}, // R5
    '{OP_WR, 4'd4,  8'h0B, 18'h40,    8'h00}, // R4 free-run
    '{OP_WR, 4'd6,  8'h06, 18'h02,    8'h00}, // R6
    '{OP_WR, 4'd2,  8'h05, 18'h00,    8'h00}, // R2
    '{OP_TK, 4'd4,  8'h00, 18'd3,     8'h00}, // R4
    '{OP_RD, 4'd4,  8'h0D, 18'd0,     8'hC0}, // R4
    '{OP_RD, 4'd4,  8'h04, 18'd0,     8'h02}, // R4 reloaded
    '{OP_RD, 4'd7,  8'h0D, 18'd0,     8'h00}, // R7
    '{OP_TK, 4'd4,  8'h00, 18'd3,     8'h00}, // R4 again
    '{OP_RD, 4'd4,  8'h0D, 18'd0,     8'hC0}, // R4
    '{OP_WR, 4'd8,  8'h0D, 18'h40,    8'h00}, // R8 write-one clear
    '{OP_RD, 4'd8,  8'h0D, 18'd0,     8'h00}, // R8
    '{OP_RD, 4'd12, 8'h54, 18'd0,     8'h02}, // R12 mirror
    '{OP_WR, 4'd11, 8'h30, 18'hA5,    8'h00}, // R11
    '{OP_RD, 4'd12, 8'hF0, 18'd0,     8'hA5}, // R12
    '{OP_WR, 4'd9,  8'h0E, 18'h40,    8'h00}, // R9 clear enable
    '{OP_RD, 4'd9,  8'h0E, 18'd0,     8'h80}, // R9
    '{OP_TK, 4'd8,  8'h00, 18'd3,     8'h00}, // R8
    '{OP_RD, 4'd8,  8'h0D, 18'd0,     8'h40}, // R8 masked
    '{OP_IRQ,4'd8,  8'h00, 18'd0,     8'h00}, // R8
    '{OP_WR, 4'd10, 8'h07, 18'h00,    8'h00}, // R10
    '{OP_RD, 4'd10, 8'h0D, 18'd0,     8'h00}, // R10 flag cleared
    '{OP_WR, 4'd10, 8'h07, 18'h12,    8'h00}, // R10
    '{OP_RD, 4'd10, 8'h05, 18'd0,     8'h00}, // R10 counter intact
    '{OP_RD, 4'd6,  8'h07, 18'd0,     8'h12}, // R6
    '{OP_WR, 4'd6,  8'h04, 18'h07,    8'h00}, // R6
    '{OP_RD, 4'd6,  8'h06, 18'd0,     8'h07}, // R6
    '{OP_RD, 4'd6,  8'h04, 18'd0,     8'h02}, // R6
    '{OP_RD, 4'd11, 8'h1B, 18'd0,     8'h40}, // R11 aux readback
    '{OP_WR, 4'd11, 8'h0C, 18'h3C,    8'h00}, // R11
    '{OP_RD, 4'd11, 8'h2C, 18'd0,     8'h3C}  // R11
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, cs = 1'b0, we = 1'b0, re = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  tmr_top uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cs(cs), .we(we), .re(re),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic tk);
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d; tick = tk;
    @(negedge clk); cs = 0; we = 0; tick = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic tk, output logic [7:0] v);
    @(negedge clk); cs = 1; re = 1; addr = a; tick = tk;
    @(negedge clk); cs = 0; re = 0; tick = 0; v = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h0D, 0, v); check(1, v, 8'h00, "flags after reset");
    rd(8'h0E, 0, v); check(1, v, 8'h80, "enable after reset");
    rd(8'h04, 0, v); check(1, v, 8'h00, "counter after reset");
    check(1, {7'd0, irq}, 8'h00, "irq after reset");

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_WR: wr(VECS[i].addr, VECS[i].arg[7:0], 1'b0);
        OP_RD: begin
          rd(VECS[i].addr, 1'b0, v);
          check(int'(VECS[i].req), v, VECS[i].exp, $sformatf("vector %0d", i));
        end
        OP_TK: ticks(int'(VECS[i].arg));
        default: check(int'(VECS[i].req), {7'd0, irq}, VECS[i].exp, $sformatf("vector %0d irq", i));
      endcase
    end

    // R7 flag set wins over read clear in the same cycle
    wr(8'h0E, 8'hC0, 0);
    wr(8'h06, 8'h01, 0);
    wr(8'h07, 8'h00, 0);
    wr(8'h05, 8'h00, 0);
    ticks(1);
    rd(8'h04, 1, v); check(7, v, 8'h00, "counter at race");
    rd(8'h0D, 0, v); check(7, v, 8'hC0, "set beats read clear");
    check(7, {7'd0, irq}, 8'h01, "irq after race");
    rd(8'h04, 0, v); check(4, v, 8'h01, "reload after race");

    // R2 load beats tick
    wr(8'h06, 8'h05, 0);
    wr(8'h05, 8'h00, 1);
    rd(8'h04, 0, v); check(2, v, 8'h05, "load over tick");

    // R1 reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(8'h06, 0, v); check(1, v, 8'h00, "latch after reset");
    rd(8'h0E, 0, v); check(1, v, 8'h80, "enable after reset 2");
    rd(8'h00, 0, v); check(1, v, 8'h00, "plain byte after reset");
    rd(8'h0B, 0, v); check(1, v, 8'h00, "aux after reset");
    check(1, {7'd0, irq}, 8'h00, "irq after reset 2");

    done = 1'b1;
    finish_run();
  end

endmodule